// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block gathers up to sixteen level-type interrupt sources on a board controller and folds them into one interrupt line toward a host processor. Each source passes through two independent gates, an enable and a mask. Each gate has its own pair of write-one-to-set and write-one-to-clear registers. A pending vector latches every enabled source that is high. The host reads this vector and acknowledges bits by writing ones to it. It services the bits from the lowest index upward, one source per bit.

The register bus is 16 bits wide, and the registers are placed on 32-bit boundaries. Reads return data combinationally in the same cycle as the access. Writes take effect at the next clock edge. The host line is a register. It follows the gated pending state one clock later.

Top module: `irq_cascade_regs`

## Requirements
- R1: After reset the enable, mask and pending vectors are all zero, every register reads 0x0000, and `hostIrq` is low.
- R2: A write to word offset 0x04 sets every enable bit whose data bit is 1, and a write to 0x08 clears every enable bit whose data bit is 1. Zero data bits leave the enable bit unchanged. Reads at 0x04 and 0x08 both return the enable vector.
- R3: Writes to 0x0C and 0x10 set and clear the mask bits with the same write-one rule. Reads at either offset return the mask vector.
- R4: A pending bit becomes 1 at the clock edge that ends any cycle in which its source is high and its enable bit is 1. A disabled source never sets its bit. A read at 0x00 returns the pending vector.
- R5: Writing a 1 to a bit of offset 0x00 clears that pending bit, and zero bits are untouched. If the source is high and enabled in the same cycle, the bit stays set.
- R6: `hostIrq` is registered. In each cycle it equals the OR over all sources of (pending AND enable AND mask) as that state stood in the previous cycle.
- R7: A pending source reaches `hostIrq` only when both its enable bit and its mask bit are 1. Closing either gate alone blocks it, and the pending bit stays readable.
- R8: An access with a nonzero address in bits [1:0], or with a word offset of 0x14 or above, reads 0x0000 and changes no state. With `busSel` low, nothing changes.
- R9: Writing 0xFFFF to the enable-clear, mask-clear and status registers, in that order, leaves every source disabled, masked and not pending, with `hostIrq` low, even while all sources are held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | NSRC | Write data |
| busRdata | output | NSRC | Read data, valid in the access cycle |
| srcIrq | input | NSRC | Level interrupt sources |
| hostIrq | output | 1 | Registered cascaded interrupt to the host |

## Verification
The bench targets four corner cases.

- **Acknowledge while the source is still high and enabled.** A design that lets the clear win would drop a live interrupt, so the status read would show 0 where 1 is expected.
- **Closing only one of the two gates.** A design that ORs the gates, or ignores one of them, would keep `hostIrq` high.
- **The full 0xFFFF initialisation sequence with all sources held high.** A design that sets pending bits regardless of enable would read back nonzero status after the sequence.
- **Unaligned and unused offsets.** Decoding only some address bits would alias these accesses onto real registers, so a stray write would change the enable or mask vector.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_EN   = 2'd2,
    RD_MSK  = 2'd3
  } irqcRdSel_e;

  typedef struct packed {
    logic       stAck;
    logic       enSet;
    logic       enClr;
    logic       mskSet;
    logic       mskClr;
    irqcRdSel_e rdSel;
  } irqcStrb_t;

  // word indices (byte offset / 4)
  localparam int IDX_STAT   = 0;
  localparam int IDX_ENSET  = 1;
  localparam int IDX_ENCLR  = 2;
  localparam int IDX_MSKSET = 3;
  localparam int IDX_MSKCLR = 4;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output irqcStrb_t         strb
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  logic             doWr;
  logic             doRd;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign doWr    = busSel && busWr && aligned;
  assign doRd    = busSel && !busWr && aligned;

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (doWr) begin
      case (wordIdx)
        IDX_W'(IDX_STAT):   strb.stAck  = 1'b1;
        IDX_W'(IDX_ENSET):  strb.enSet  = 1'b1;
        IDX_W'(IDX_ENCLR):  strb.enClr  = 1'b1;
        IDX_W'(IDX_MSKSET): strb.mskSet = 1'b1;
        IDX_W'(IDX_MSKCLR): strb.mskClr = 1'b1;
        default: ;
      endcase
    end
    if (doRd) begin
      case (wordIdx)
        IDX_W'(IDX_STAT):                     strb.rdSel = RD_STAT;
        IDX_W'(IDX_ENSET), IDX_W'(IDX_ENCLR):   strb.rdSel = RD_EN;
        IDX_W'(IDX_MSKSET), IDX_W'(IDX_MSKCLR): strb.rdSel = RD_MSK;
        default:                              strb.rdSel = RD_NONE;
      endcase
    end
  end

  // R8: a single access never raises more than one write strobe
  always_comb begin
    assert_one_strobe_R8: assert ($onehot0({strb.stAck, strb.enSet, strb.enClr,
                                            strb.mskSet, strb.mskClr}));
  end

  // R8: no read selection during a write or an idle cycle
  always_comb begin
    assert_no_read_on_write_R8: assert (!(busWr || !busSel) || (strb.rdSel == RD_NONE) || !aligned
                                        || (strb.rdSel == RD_NONE));
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  irqcStrb_t       strb,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] srcIrq,
  output logic [NSRC-1:0] rdata,
  output logic            hostIrq
);
  logic [NSRC-1:0] enable;
  logic [NSRC-1:0] mask;
  logic [NSRC-1:0] pending;

  for (genvar i = 0; i < NSRC; i++) begin : gSrc
    logic enQ;
    logic mkQ;
    logic pdQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ <= 1'b0;
        mkQ <= 1'b0;
        pdQ <= 1'b0;
      end else begin
        if (strb.enSet && wdata[i])      enQ <= 1'b1;
        else if (strb.enClr && wdata[i]) enQ <= 1'b0;

        if (strb.mskSet && wdata[i])      mkQ <= 1'b1;
        else if (strb.mskClr && wdata[i]) mkQ <= 1'b0;

        // a live enabled source wins over an acknowledge
        if (srcIrq[i] && enQ)            pdQ <= 1'b1;
        else if (strb.stAck && wdata[i]) pdQ <= 1'b0;
      end
    end

    assign enable[i]  = enQ;
    assign mask[i]    = mkQ;
    assign pending[i] = pdQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostIrq <= 1'b0;
    else       hostIrq <= |(pending & enable & mask);
  end

  always_comb begin
    case (strb.rdSel)
      RD_STAT: rdata = pending;
      RD_EN:   rdata = enable;
      RD_MSK:  rdata = mask;
      default: rdata = '0;
    endcase
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.enSet |=> ((enable & $past(wdata)) == $past(wdata)));

  assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.enClr |=> ((enable & $past(wdata)) == '0));

  assert_msk_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.mskSet |=> ((mask & $past(wdata)) == $past(wdata)));

  assert_msk_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.mskClr |=> ((mask & $past(wdata)) == '0));

  assert_pend_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((srcIrq & enable) != '0) |=> ((pending & $past(srcIrq & enable)) == $past(srcIrq & enable)));

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.stAck |=> ((pending & $past(wdata) & ~$past(srcIrq & enable)) == '0));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> ($past(pending) != '0));

  assert_gate_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((enable & mask) == '0) |=> !hostIrq);

endmodule

// File: rtl/irq_cascade_regs.sv
module irq_cascade_regs
  import irqc_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NSRC-1:0]   busWdata,
  output logic [NSRC-1:0]   busRdata,
  input  logic [NSRC-1:0]   srcIrq,
  output logic              hostIrq
);
  irqcStrb_t strb;

  irqc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  irqc_datapath #(.NSRC(NSRC)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wdata  (busWdata),
    .srcIrq (srcIrq),
    .rdata  (busRdata),
    .hostIrq(hostIrq)
  );

endmodule

// File: tb/irq_cascade_regs_tb.sv
`timescale 1ns/1ps
module irq_cascade_regs_tb;
  localparam int NSRC   = 16;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rstN;
  logic              busSel;
  logic              busWr;
  logic [ADDR_W-1:0] busAddr;
  logic [NSRC-1:0]   busWdata;
  logic [NSRC-1:0]   busRdata;
  logic [NSRC-1:0]   srcIrq;
  logic              hostIrq;

  always #2 clk = ~clk;

  irq_cascade_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIrq(srcIrq), .hostIrq(hostIrq)
  );

  int checks = 0;
  int errors = 0;
  logic [NSRC-1:0] mEn, mMsk, mPend;
  logic            mIrq;

  function automatic logic [NSRC-1:0] expRead(logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[ADDR_W-1:2])
      3'd0:       return mPend;
      3'd1, 3'd2: return mEn;
      3'd3, 3'd4: return mMsk;
      default:    return '0;
    endcase
  endfunction

  function automatic string reqOf(logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00) return "R8";
    case (a[ADDR_W-1:2])
      3'd0:       return "R4";
      3'd1, 3'd2: return "R2";
      3'd3, 3'd4: return "R3";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [NSRC-1:0] act, logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; leaves at the next negedge
  task automatic cycle(string tag, logic sel, logic wr, logic [ADDR_W-1:0] addr,
                       logic [NSRC-1:0] data, logic [NSRC-1:0] src);
    logic [NSRC-1:0] nEn, nMsk, nPend;
    logic            wok;
    busSel = sel; busWr = wr; busAddr = addr; busWdata = data; srcIrq = src;
    #1;
    if (sel && !wr) check((tag != "") ? tag : reqOf(addr), busRdata, expRead(addr));
    @(posedge clk);
    wok   = sel && wr && (addr[1:0] == 2'b00);
    nEn   = mEn;
    nMsk  = mMsk;
    nPend = mPend;
    if (wok) begin
      case (addr[ADDR_W-1:2])
        3'd0: nPend = mPend & ~data;
        3'd1: nEn   = mEn | data;
        3'd2: nEn   = mEn & ~data;
        3'd3: nMsk  = mMsk | data;
        3'd4: nMsk  = mMsk & ~data;
        default: ;
      endcase
    end
    nPend = nPend | (src & mEn);
    mIrq  = |(mPend & mEn & mMsk);
    mEn = nEn; mMsk = nMsk; mPend = nPend;
    @(negedge clk);
    check("R6 hostIrq", {15'd0, hostIrq}, {15'd0, mIrq});
  endtask

  task automatic wr(string tag, logic [ADDR_W-1:0] a, logic [NSRC-1:0] d, logic [NSRC-1:0] s);
    cycle(tag, 1'b1, 1'b1, a, d, s);
  endtask

  task automatic rd(string tag, logic [ADDR_W-1:0] a, logic [NSRC-1:0] s);
    cycle(tag, 1'b1, 1'b0, a, '0, s);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; busSel = 0; busWr = 0; busAddr = '0; busWdata = '0; srcIrq = '1;
    mEn = '0; mMsk = '0; mPend = '0; mIrq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    srcIrq = '0;

    // R1 reset state
    check("R1 hostIrq", {15'd0, hostIrq}, '0);
    rd("R1", 5'h00, '0);
    rd("R1", 5'h04, '0);
    rd("R1", 5'h0C, '0);

    // R2/R3 write-one semantics
    wr("R2", 5'h04, 16'h00F3, '0);
    wr("R2", 5'h08, 16'h0011, '0);
    rd("R2", 5'h08, '0);
    wr("R3", 5'h0C, 16'hA5A5, '0);
    wr("R3", 5'h10, 16'h0005, '0);
    rd("R3", 5'h0C, '0);

    // R4 latch only enabled sources
    cycle("R4", 1'b0, 1'b0, 5'h00, '0, 16'hFF00);
    rd("R4", 5'h00, '0);
    cycle("R4", 1'b0, 1'b0, 5'h00, '0, 16'h0003);
    rd("R4", 5'h00, '0);

    // R5 ack with source low clears; with source high stays set
    wr("R5", 5'h00, 16'h0001, '0);
    rd("R5", 5'h00, '0);
    wr("R5", 5'h00, 16'h0002, 16'h0002);
    rd("R5", 5'h00, '0);
    wr("R5", 5'h00, 16'hFFFF, '0);
    rd("R5", 5'h00, '0);

    // R7 one gate closed blocks; both open pass
    wr("R7", 5'h04, 16'h0100, '0);
    wr("R7", 5'h10, 16'h0100, 16'h0100);
    cycle("R7", 1'b0, 1'b0, 5'h00, '0, '0);
    check("R7 blocked by mask", {15'd0, hostIrq}, '0);
    rd("R7", 5'h00, '0);
    wr("R7", 5'h0C, 16'h0100, '0);
    cycle("R7", 1'b0, 1'b0, 5'h00, '0, '0);
    check("R7 both open", {15'd0, hostIrq}, 16'd1);
    wr("R7", 5'h08, 16'h0100, '0);
    cycle("R7", 1'b0, 1'b0, 5'h00, '0, '0);
    check("R7 blocked by enable", {15'd0, hostIrq}, '0);
    rd("R7", 5'h00, '0);

    // R8 unused and unaligned offsets
    wr("R8", 5'h14, 16'hFFFF, '0);
    wr("R8", 5'h05, 16'hFFFF, '0);
    wr("R8", 5'h1C, 16'hFFFF, '0);
    rd("R8", 5'h18, '0);
    rd("R8", 5'h06, '0);
    rd("R8", 5'h04, '0);
    cycle("R8", 1'b0, 1'b1, 5'h04, 16'hFFFF, '0);
    rd("R8", 5'h04, '0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] a;
      logic [NSRC-1:0]   d;
      logic [NSRC-1:0]   s;
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 7)       a = ADDR_W'(pick * 4);
      else if (pick == 7) a = 5'h14 + ADDR_W'($urandom_range(0, 2) * 4);
      else                a = ADDR_W'($urandom_range(0, 31));
      d = NSRC'($urandom);
      s = NSRC'($urandom) & NSRC'($urandom);
      cycle("", ($urandom_range(0, 3) != 0), ($urandom_range(0, 1) == 1), a, d, s);
    end

    // R9 init sequence with all sources high
    wr("R9", 5'h04, 16'hFFFF, '1);
    wr("R9", 5'h0C, 16'hFFFF, '1);
    wr("R9", 5'h08, 16'hFFFF, '1);
    wr("R9", 5'h10, 16'hFFFF, '1);
    wr("R9", 5'h00, 16'hFFFF, '1);
    rd("R9", 5'h00, '1);
    rd("R9", 5'h04, '1);
    rd("R9", 5'h0C, '1);
    cycle("R9", 1'b0, 1'b0, 5'h00, '0, '1);
    check("R9 hostIrq", {15'd0, hostIrq}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule